// File: doc/BRIEF.md
# ARINC 429 Parity Insertion and Check

This unit owns the top bit of each ARINC 429 word, on both directions of a channel. On the send side a host hands over a word together with a parity mode. In odd or even mode the unit counts the ones in the lower bits and replaces the top bit with the bit that gives the whole word the chosen parity. In the none mode the host's own top bit goes out untouched. Either way, the host cannot choose the parity bit while odd or even mode is active.

On the receive side the deserializer hands over a finished word. The bus parity bit is not passed on. The unit counts the ones across the whole received word, parity bit included, and writes a status into the top bit: 0 when the count is odd and 1 when it is even. In a checking mode it also raises a parity error flag beside the word.

Each path is a one-stage valid/ready register slice. A word is accepted on a rising edge where `*_in_valid` and `*_in_ready` are both high. It appears on `*_out_valid` after that edge. The slice holds a presented word, unchanged, for as long as `*_out_ready` is low. The input side is ready whenever the slice is empty or is being emptied in the same cycle, so a path moves one word per cycle when nothing stalls it. The mode pins are plain control inputs. They are sampled together with the word on the edge where that word is accepted.

Top module: `arinc_parity_unit`

## Requirements
- R1: With transmit mode code 1 (odd), the transmitted word has an odd count of ones over all WORD_W bits. Its bits below the top equal the host's bits.
- R2: With transmit mode code 2 (even), the transmitted word has an even count of ones over all WORD_W bits. Its bits below the top equal the host's bits.
- R3: In transmit mode 1 or 2, the host's top bit (bit 32, the vector MSB) has no effect on the transmitted word.
- R4: With transmit mode code 0 or 3 (none), the transmitted word equals the host word in every bit, the top bit included.
- R5: The received output word equals the input word below the top bit. Its top bit is 0 when the input word, bus parity bit included, holds an odd number of ones, and 1 when it holds an even number.
- R6: With receive mode code 1 (odd), `rx_out_err` is high exactly when the presented top bit is 1. With receive mode code 2 (even), it is high exactly when the presented top bit is 0.
- R7: With receive mode code 0 or 3 (disabled), `rx_out_err` stays low and the top bit is still computed as in R5.
- R8: `rx_out_err` is registered, is high only while `rx_out_valid` is high, and belongs to the word currently presented.
- R9: A word accepted on a rising edge is presented with its output valid high right after that edge. With no new input and the output ready, valid drops after the next edge.
- R10: While an output valid is high and its ready is low, the output word and valid stay unchanged and the input ready is low. Input ready equals "output not valid, or output ready".
- R11: Right after reset, both output valids and `rx_out_err` are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 2 | Transmit parity: 0/3 none, 1 odd, 2 even |
| tx_in_valid | input | 1 | Host word available |
| tx_in_ready | output | 1 | Transmit slice can accept |
| tx_in_word | input | WORD_W | Host word, bit 1 at index 0 |
| tx_out_valid | output | 1 | Transmit word presented |
| tx_out_ready | input | 1 | Serializer takes the word |
| tx_out_word | output | WORD_W | Word with parity applied |
| rx_mode | input | 2 | Receive check: 0/3 off, 1 odd, 2 even |
| rx_in_valid | input | 1 | Deserialized word available |
| rx_in_ready | output | 1 | Receive slice can accept |
| rx_in_word | input | WORD_W | Word as received from the bus |
| rx_out_valid | output | 1 | Received word presented |
| rx_out_ready | input | 1 | Consumer takes the word |
| rx_out_word | output | WORD_W | Word with computed status in the top bit |
| rx_out_err | output | 1 | Parity error for the presented word |

## Verification
The bench builds two instances. One uses the default WORD_W of 32. The other uses WORD_W of 8, where every possible word can be driven under all four mode codes on both paths. This small instance covers every ones count and both top-bit values, so each mode and parity combination gets an exhaustive check. The 32-bit instance sees structured patterns, walking ones, all-zero and all-one words, and a stall sequence that exercises the hold and ready rules.

// File: rtl/arinc_par_pkg.sv
package arinc_par_pkg;

  typedef enum logic [1:0] {
    PM_OFF     = 2'd0,
    PM_ODD     = 2'd1,
    PM_EVEN    = 2'd2,
    PM_OFF_ALT = 2'd3
  } par_mode_e;

  function automatic logic mode_checks(par_mode_e m);
    return (m == PM_ODD) || (m == PM_EVEN);
  endfunction

endpackage

// File: rtl/arinc_stream_slice.sv
module arinc_stream_slice #(
  parameter int DATA_W = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (in_ready) full_q <= in_valid;
      if (in_valid && in_ready) data_q <= in_data;
    end
  end

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/arinc_tx_parity.sv
module arinc_tx_parity
  import arinc_par_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  par_mode_e         mode,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out
);

  localparam int LOW_W = WORD_W - 1;

  logic low_odd;
  logic top_bit;

  assign low_odd = ^word_in[LOW_W-1:0];

  always_comb begin
    case (mode)
      PM_ODD:  top_bit = ~low_odd;
      PM_EVEN: top_bit = low_odd;
      default: top_bit = word_in[WORD_W-1];
    endcase
  end

  assign word_out = {top_bit, word_in[LOW_W-1:0]};

  always_comb begin
    if (mode == PM_ODD)  assert_tx_odd_R1: assert (^word_out == 1'b1);
    if (mode == PM_EVEN) assert_tx_even_R2: assert (^word_out == 1'b0);
  end

endmodule

// File: rtl/arinc_rx_parity.sv
module arinc_rx_parity
  import arinc_par_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  par_mode_e         mode,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out,
  output logic              err
);

  localparam int LOW_W = WORD_W - 1;

  logic status_bit;

  assign status_bit = ~(^word_in);
  assign word_out   = {status_bit, word_in[LOW_W-1:0]};

  always_comb begin
    case (mode)
      PM_ODD:  err = status_bit;
      PM_EVEN: err = ~status_bit;
      default: err = 1'b0;
    endcase
  end

  always_comb begin
    if (!mode_checks(mode)) assert_rx_quiet_R7: assert (!err);
  end

endmodule

// File: rtl/arinc_parity_unit.sv
module arinc_parity_unit
  import arinc_par_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tx_mode,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [WORD_W-1:0] tx_in_word,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [WORD_W-1:0] tx_out_word,
  input  logic [1:0]        rx_mode,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [WORD_W-1:0] rx_in_word,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [WORD_W-1:0] rx_out_word,
  output logic              rx_out_err
);

  localparam int RX_SLICE_W = WORD_W + 1;

  logic [WORD_W-1:0]     tx_shaped;
  logic [WORD_W-1:0]     rx_shaped;
  logic                  rx_flag;
  logic [RX_SLICE_W-1:0] rx_slice_q;

  arinc_tx_parity #(.WORD_W(WORD_W)) u_tx_par (
    .mode     (par_mode_e'(tx_mode)),
    .word_in  (tx_in_word),
    .word_out (tx_shaped)
  );

  arinc_stream_slice #(.DATA_W(WORD_W)) u_tx_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   (tx_shaped),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_word)
  );

  arinc_rx_parity #(.WORD_W(WORD_W)) u_rx_par (
    .mode     (par_mode_e'(rx_mode)),
    .word_in  (rx_in_word),
    .word_out (rx_shaped),
    .err      (rx_flag)
  );

  arinc_stream_slice #(.DATA_W(RX_SLICE_W)) u_rx_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   ({rx_flag, rx_shaped}),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_slice_q)
  );

  assign rx_out_word = rx_slice_q[WORD_W-1:0];
  assign rx_out_err  = rx_out_valid & rx_slice_q[WORD_W];

  assert_tx_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && !mode_checks(par_mode_e'(tx_mode)))
      |=> (tx_out_word == $past(tx_in_word)));

  assert_tx_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready)
      |=> (tx_out_word[WORD_W-2:0] == $past(tx_in_word[WORD_W-2:0])));

  assert_rx_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_ready)
      |=> (rx_out_word[WORD_W-1] == ~(^$past(rx_in_word))));

  assert_rx_odd_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_ready && rx_mode == 2'd1)
      |=> (rx_out_err == rx_out_word[WORD_W-1]));

  assert_rx_even_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_ready && rx_mode == 2'd2)
      |=> (rx_out_err == !rx_out_word[WORD_W-1]));

  assert_err_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_err |-> rx_out_valid);

  assert_reset_state_R11: assert property (@(posedge clk)
    !rst_n |=> (!tx_out_valid && !rx_out_valid && !rx_out_err));

endmodule

// File: tb/arinc_parity_unit_test.sv
module arinc_parity_unit_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [1:0]  txm, rxm;
  logic        tiv, riv, tor, ror;
  logic [31:0] tiw, riw;
  logic [7:0]  tiw8, riw8;

  logic        tir, tov, rir, rov, rerr;
  logic [31:0] tow, row;
  logic        tir8, tov8, rir8, rov8, rerr8;
  logic [7:0]  tow8, row8;

  arinc_parity_unit uut (
    .clk(clk), .rst_n(rst_n),
    .tx_mode(txm), .tx_in_valid(tiv), .tx_in_ready(tir), .tx_in_word(tiw),
    .tx_out_valid(tov), .tx_out_ready(tor), .tx_out_word(tow),
    .rx_mode(rxm), .rx_in_valid(riv), .rx_in_ready(rir), .rx_in_word(riw),
    .rx_out_valid(rov), .rx_out_ready(ror), .rx_out_word(row), .rx_out_err(rerr)
  );

  arinc_parity_unit #(.WORD_W(8)) uut_small (
    .clk(clk), .rst_n(rst_n),
    .tx_mode(txm), .tx_in_valid(tiv), .tx_in_ready(tir8), .tx_in_word(tiw8),
    .tx_out_valid(tov8), .tx_out_ready(tor), .tx_out_word(tow8),
    .rx_mode(rxm), .rx_in_valid(riv), .rx_in_ready(rir8), .rx_in_word(riw8),
    .rx_out_valid(rov8), .rx_out_ready(ror), .rx_out_word(row8), .rx_out_err(rerr8)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tx_exp(logic [31:0] w, int n, int m);
    int c = 0;
    logic [31:0] r = 0;
    for (int i = 0; i < n - 1; i++) begin
      c += int'(w[i]);
      r[i] = w[i];
    end
    if (m == 1)      r[n-1] = (c % 2 == 0);
    else if (m == 2) r[n-1] = (c % 2 == 1);
    else             r[n-1] = w[n-1];
    return r;
  endfunction

  function automatic logic [32:0] rx_exp(logic [31:0] w, int n, int m);
    int c = 0;
    logic [31:0] r = 0;
    logic top, e;
    for (int i = 0; i < n; i++) begin
      c += int'(w[i]);
      if (i < n - 1) r[i] = w[i];
    end
    top = (c % 2 == 0);
    r[n-1] = top;
    e = (m == 1 && top) || (m == 2 && !top);
    return {e, r};
  endfunction

  function automatic string tx_tag(int m);
    if (m == 1) return "R1 R3";
    if (m == 2) return "R2 R3";
    return "R4";
  endfunction

  function automatic string err_tag(int m);
    if (m == 1 || m == 2) return "R6";
    return "R7";
  endfunction

  task automatic step(logic [31:0] w32, logic [7:0] w8, int tm, int rm);
    logic [32:0] rb, rs;
    @(negedge clk);
    tiv = 1; riv = 1; tiw = w32; riw = w32; tiw8 = w8; riw8 = w8;
    txm = 2'(tm); rxm = 2'(rm);
    @(posedge clk); #1;
    rb = rx_exp(w32, 32, rm);
    rs = rx_exp({24'd0, w8}, 8, rm);
    chk(tx_tag(tm), tow, tx_exp(w32, 32, tm));
    chk(tx_tag(tm), {24'd0, tow8}, tx_exp({24'd0, w8}, 8, tm));
    chk("R5", row, rb[31:0]);
    chk("R5", {24'd0, row8}, rs[31:0]);
    chk(err_tag(rm), {31'd0, rerr}, {31'd0, rb[32]});
    chk(err_tag(rm), {31'd0, rerr8}, {31'd0, rs[32]});
    chk("R9", {28'd0, tov, rov, tov8, rov8}, 32'hF);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    txm = 0; rxm = 0; tiv = 0; riv = 0; tor = 1; ror = 1;
    tiw = 0; riw = 0; tiw8 = 0; riw8 = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", {27'd0, tov, rov, rerr, tir, rir}, 32'h3);
    chk("R11", {27'd0, tov8, rov8, rerr8, tir8, rir8}, 32'h3);
    @(negedge clk); rst_n = 1;

    for (int m = 0; m < 4; m++)
      for (int v = 0; v < 256; v++)
        step({8'(v), 8'(v) ^ 8'hA5, ~8'(v), 8'(v)}, 8'(v), (m + 1) % 4, m);

    for (int m = 0; m < 4; m++) begin
      step(32'h0, 8'h00, m, m);
      step(32'hFFFF_FFFF, 8'hFF, m, m);
      for (int b = 0; b < 32; b++) step(32'h1 << b, 8'h1 << (b % 8), m, 3 - m);
    end

    // R3: top host bit flipped, same output in odd/even
    for (int m = 1; m < 3; m++) begin
      logic [31:0] a;
      step(32'h1234_5678, 8'h12, m, 0); a = tow;
      step(32'h9234_5678, 8'h92, m, 0);
      chk("R3", tow, a);
    end

    // R9: valid drops after an idle edge
    @(negedge clk); tiv = 0; riv = 0;
    @(posedge clk); #1;
    chk("R9", {30'd0, tov, rov}, 32'h0);
    chk("R8", {31'd0, rerr}, 32'h0);

    // R10: back-pressure on the 32-bit instance
    @(negedge clk); tor = 0; ror = 0;
    tiv = 1; riv = 1; txm = 0; rxm = 1; tiw = 32'hAAAA_0001; riw = 32'h0000_0001;
    @(posedge clk); #1;
    chk("R10", tow, 32'hAAAA_0001);
    @(negedge clk); tiw = 32'h5555_0002; riw = 32'h0000_0003;
    #1;
    chk("R10", {30'd0, tir, rir}, 32'h0);
    @(posedge clk); #1;
    chk("R10", tow, 32'hAAAA_0001);
    chk("R10", row, 32'h0000_0001);
    chk("R8", {30'd0, rov, rerr}, 32'h2);
    @(negedge clk); tor = 1; ror = 1;
    #1;
    chk("R10", {30'd0, tir, rir}, 32'h3);
    @(posedge clk); #1;
    chk("R10", tow, 32'h5555_0002);
    chk("R8", {31'd0, rerr}, 32'h1);
    chk("R5", row, 32'h8000_0003);
    @(negedge clk); tiv = 0; riv = 0;
    @(posedge clk); #1;
    chk("R8", {30'd0, rov, rerr}, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule